// File: doc/BRIEF.md
# Pixel to Bus Cycle Formatter

This block sits between a pixel source and the strobe engine of a parallel display bus. Each incoming pixel is 12, 16, 18 or 24 bits deep; the outgoing bus carries 8, 9, 12 or 16 data lines. The formatter breaks every pixel into as many bus words as the ratio of depth to width demands, most significant part first. When the depth is one and a half times the bus width, two pixels are packed into three bus words: the middle word holds the tail of the first pixel and the head of the second.

Software sets the two format codes and the number of pixels in the frame (width times height), then pulses a start input. The block accepts pixels over a valid/ready handshake, hands bus words downstream over a second valid/ready handshake, and raises a one-clock frame-done pulse once the last word of the frame has been taken. The busy output acts as the enable bit: it is set by the start and clears by itself at the end of the frame.

Top module: `pix_fmt_top`

## Requirements
- R1: `cfgBus` codes 0,1,2,3 mean 8, 9, 12 and 16 lines; `cfgPix` codes 0,1,2,3 mean 12, 16, 18 and 24 bits. Combinationally, `fmtCode` gives 0 when depth equals width, 1 when depth is twice width, 2 when three times, 3 when depth times two equals width times three, with `fmtOk` high; any other pair drives `fmtOk` low and `fmtCode` 0.
- R2: For codes 0 to 2, each pixel of depth D gives D/W words of W bits; word k carries pixel bits [D-1-k*W : D-(k+1)*W], in `wordData[W-1:0]` with all higher bits zero.
- R3: For code 3, pixels A then B form the 2D-bit value {A,B}, sent as three W-bit words from the most significant end, so the middle word is the low W/2 bits of A above the high W/2 bits of B.
- R4: In code 3 an odd final pixel of the frame is paired with an all-zero second pixel and still produces three words.
- R5: Bits of `pixData` at or above the selected depth have no effect on the words.
- R6: A start pulse while idle, with `fmtOk` high and a non-zero `frameLen`, raises `busy` at the next edge; a start with an unsupported pair or zero length leaves `busy` low.
- R7: Format codes and length are captured at start; changes to them, and further start pulses, while busy have no effect on the frame.
- R8: `frameDone` is high for exactly one clock, in the cycle after the last word of the frame is accepted, and `busy` is low in that same cycle.
- R9: While `wordValid` is high and `wordReady` low, `wordData` holds; `pixReady` and `wordValid` are never high together.
- R10: After reset `busy`, `frameDone`, `pixReady`, `wordValid` and `wordData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts a frame when idle |
| cfgBus | input | 2 | Bus line count code |
| cfgPix | input | 2 | Pixel depth code |
| frameLen | input | CNT_W | Pixels in the frame |
| fmtOk | output | 1 | Current code pair is supported |
| fmtCode | output | 2 | Cycle format of current code pair |
| busy | output | 1 | Frame in progress |
| frameDone | output | 1 | One-clock end-of-frame pulse |
| pixValid | input | 1 | Pixel offered |
| pixReady | output | 1 | Pixel taken this cycle when valid |
| pixData | input | 24 | Pixel, right-aligned |
| wordValid | output | 1 | Bus word offered |
| wordReady | input | 1 | Downstream takes the word |
| wordData | output | 16 | Bus word, right-aligned |

## Verification
The format decode is combinational, so its check follows the code change in the same cycle. `busy` and `pixReady` appear one edge after the start edge, a pixel's first word is offered one edge after the pixel handshake, each further word one edge after the previous word is taken, and `frameDone` rises one edge after the final word handshake. The bench drives inputs at the falling edge, looks at handshake outputs shortly after it, and counts the rising edge at which a handshake completes before it samples the next result, so every comparison lands in the cycle the requirement names; stalled `wordReady` patterns stretch those cycles without changing the expected words.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int PIX_W = 24;
  localparam int BUS_W = 16;
  localparam int SH_W  = 2 * PIX_W;

  typedef enum logic [1:0] {F1x1 = 2'd0, F2x1 = 2'd1, F3x1 = 2'd2, F3x2 = 2'd3} cycFmt_e;

  typedef struct packed {
    logic       loadOne;   // single pixel (or padded pair) into the shifter
    logic       loadHold;  // first pixel of a pair into the holding register
    logic       loadPair;  // second pixel joins the held one
    logic       shiftOut;  // current word accepted downstream
    logic [1:0] busCode;
    logic [1:0] pixCode;
  } fmtStrobe_t;

  function automatic logic [4:0] busBits(input logic [1:0] c);
    case (c)
      2'd0: return 5'd8;
      2'd1: return 5'd9;
      2'd2: return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [4:0] pixBits(input logic [1:0] c);
    case (c)
      2'd0: return 5'd12;
      2'd1: return 5'd16;
      2'd2: return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  // {ok, format}
  function automatic logic [2:0] decodeFmt(input logic [1:0] bus, input logic [1:0] pix);
    int d;
    int w;
    d = int'(pixBits(pix));
    w = int'(busBits(bus));
    if (d == w) return 3'b100;
    else if (d == 2 * w) return 3'b101;
    else if (d == 3 * w) return 3'b110;
    else if (2 * d == 3 * w) return 3'b111;
    else return 3'b000;
  endfunction
endpackage

// File: rtl/pix_fmt_ctrl.sv
module pix_fmt_ctrl
  import pix_fmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [1:0]       cfgBus,
  input  logic [1:0]       cfgPix,
  input  logic [CNT_W-1:0] frameLen,
  input  logic             pixValid,
  output logic             pixReady,
  output logic             wordValid,
  input  logic             wordReady,
  output logic             busy,
  output logic             frameDone,
  output fmtStrobe_t       strobe
);
  typedef enum logic [1:0] {sIdle, sTake, sEmit} state_e;

  state_e           state;
  logic [1:0]       busReg;
  logic [1:0]       pixReg;
  cycFmt_e          fmtReg;
  logic [CNT_W-1:0] pixLeft;
  logic [1:0]       wordLeft;
  logic             halfDone;
  logic [2:0]       startDec;
  logic             pixAccept;
  logic             wordAccept;
  logic             pairMode;
  logic             lastOfFrame;

  always_comb begin
    startDec    = decodeFmt(cfgBus, cfgPix);
    pixReady    = (state == sTake);
    wordValid   = (state == sEmit);
    busy        = (state != sIdle);
    pixAccept   = pixReady && pixValid;
    wordAccept  = wordValid && wordReady;
    pairMode    = (fmtReg == F3x2);
    lastOfFrame = (pixLeft == CNT_W'(1));
    strobe.loadOne  = pixAccept && (!pairMode || (!halfDone && lastOfFrame));
    strobe.loadHold = pixAccept && pairMode && !halfDone && !lastOfFrame;
    strobe.loadPair = pixAccept && pairMode && halfDone;
    strobe.shiftOut = wordAccept;
    strobe.busCode  = busReg;
    strobe.pixCode  = pixReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= sIdle;
      busReg    <= 2'd0;
      pixReg    <= 2'd0;
      fmtReg    <= F1x1;
      pixLeft   <= '0;
      wordLeft  <= 2'd0;
      halfDone  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        sIdle: begin
          if (startPulse && startDec[2] && (frameLen != '0)) begin
            busReg   <= cfgBus;
            pixReg   <= cfgPix;
            fmtReg   <= cycFmt_e'(startDec[1:0]);
            pixLeft  <= frameLen;
            halfDone <= 1'b0;
            state    <= sTake;
          end
        end
        sTake: begin
          if (pixAccept) begin
            pixLeft <= pixLeft - CNT_W'(1);
            if (strobe.loadHold) begin
              halfDone <= 1'b1;
            end else begin
              halfDone <= 1'b0;
              wordLeft <= pairMode ? 2'd3 : (2'(fmtReg) + 2'd1);
              state    <= sEmit;
            end
          end
        end
        sEmit: begin
          if (wordAccept) begin
            wordLeft <= wordLeft - 2'd1;
            if (wordLeft == 2'd1) begin
              if (pixLeft == '0) begin
                state     <= sIdle;
                frameDone <= 1'b1;
              end else begin
                state <= sTake;
              end
            end
          end
        end
        default: state <= sIdle;
      endcase
    end
  end
endmodule

// File: rtl/pix_fmt_path.sv
module pix_fmt_path
  import pix_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fmtStrobe_t       strobe,
  input  logic [PIX_W-1:0] pixData,
  output logic [BUS_W-1:0] wordData
);
  logic [4:0]       depth;
  logic [4:0]       width;
  logic [PIX_W-1:0] aligned;
  logic [PIX_W-1:0] holdA;
  logic [SH_W-1:0]  shifter;

  always_comb begin
    depth    = pixBits(strobe.pixCode);
    width    = busBits(strobe.busCode);
    // Drop bits above the depth by pushing the pixel to the top.
    aligned  = pixData << (5'(PIX_W) - depth);
    wordData = shifter[SH_W-1 -: BUS_W] >> (5'(BUS_W) - width);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdA   <= '0;
      shifter <= '0;
    end else begin
      if (strobe.loadHold) holdA <= aligned;
      if (strobe.loadOne) begin
        shifter <= {aligned, {PIX_W{1'b0}}};
      end else if (strobe.loadPair) begin
        shifter <= {holdA, {PIX_W{1'b0}}} | ({aligned, {PIX_W{1'b0}}} >> depth);
      end else if (strobe.shiftOut) begin
        shifter <= shifter << width;
      end
    end
  end
endmodule

// File: rtl/pix_fmt_top.sv
module pix_fmt_top
  import pix_fmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [1:0]       cfgBus,
  input  logic [1:0]       cfgPix,
  input  logic [CNT_W-1:0] frameLen,
  output logic             fmtOk,
  output logic [1:0]       fmtCode,
  output logic             busy,
  output logic             frameDone,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic [23:0]      pixData,
  output logic             wordValid,
  input  logic             wordReady,
  output logic [15:0]      wordData
);
  fmtStrobe_t strobe;

  assign {fmtOk, fmtCode} = decodeFmt(cfgBus, cfgPix);

  pix_fmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .cfgBus(cfgBus), .cfgPix(cfgPix), .frameLen(frameLen),
    .pixValid(pixValid), .pixReady(pixReady),
    .wordValid(wordValid), .wordReady(wordReady),
    .busy(busy), .frameDone(frameDone), .strobe(strobe)
  );

  pix_fmt_path u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pixData(pixData), .wordData(wordData)
  );
endmodule

// File: rtl/pix_fmt_chk.sv
module pix_fmt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startPulse,
  input logic        busy,
  input logic        frameDone,
  input logic        pixReady,
  input logic        wordValid,
  input logic        wordReady,
  input logic [15:0] wordData
);
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordData)));

  // R9
  side_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pixReady && wordValid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !busy);

  // R6
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!pixReady && !wordValid));
endmodule

bind pix_fmt_top pix_fmt_chk u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy),
  .frameDone(frameDone), .pixReady(pixReady), .wordValid(wordValid),
  .wordReady(wordReady), .wordData(wordData)
);

// File: tb/pix_fmt_top_tb.sv
module pix_fmt_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [1:0]  cfgBus = 2'd0;
  logic [1:0]  cfgPix = 2'd0;
  logic [15:0] frameLen = 16'd0;
  logic        fmtOk;
  logic [1:0]  fmtCode;
  logic        busy;
  logic        frameDone;
  logic        pixValid = 1'b0;
  logic        pixReady;
  logic [23:0] pixData = 24'd0;
  logic        wordValid;
  logic        wordReady = 1'b0;
  logic [15:0] wordData;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [23:0] pixMem [8];
  logic [15:0] expW [32];
  int expN;

  // {bus code, pixel code, pixel count}
  localparam logic [7:0] VEC [11] = '{
    {2'd0, 2'd1, 4'd3}, {2'd0, 2'd3, 4'd2}, {2'd0, 2'd0, 4'd3}, {2'd0, 2'd0, 4'd4},
    {2'd1, 2'd2, 4'd2}, {2'd2, 2'd0, 4'd2}, {2'd2, 2'd2, 4'd3}, {2'd2, 2'd3, 4'd2},
    {2'd3, 2'd1, 4'd3}, {2'd3, 2'd3, 4'd4}, {2'd3, 2'd3, 4'd1}
  };

  pix_fmt_top u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgBus(cfgBus),
    .cfgPix(cfgPix), .frameLen(frameLen), .fmtOk(fmtOk), .fmtCode(fmtCode),
    .busy(busy), .frameDone(frameDone), .pixValid(pixValid), .pixReady(pixReady),
    .pixData(pixData), .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wOf(input int c);
    int t[4] = '{8, 9, 12, 16};
    return t[c];
  endfunction

  function automatic int dOf(input int c);
    int t[4] = '{12, 16, 18, 24};
    return t[c];
  endfunction

  // expected {ok, fmt} listed per supported pair
  function automatic int expFmt(input int bus, input int pix);
    case ({bus[1:0], pix[1:0]})
      4'b00_00: return 7;  // 12 on 8: 3:2
      4'b00_01: return 5;  // 16 on 8: 2:1
      4'b00_11: return 6;  // 24 on 8: 3:1
      4'b01_10: return 5;  // 18 on 9: 2:1
      4'b10_00: return 4;  // 12 on 12: 1:1
      4'b10_10: return 7;  // 18 on 12: 3:2
      4'b10_11: return 5;  // 24 on 12: 2:1
      4'b11_01: return 4;  // 16 on 16: 1:1
      4'b11_11: return 7;  // 24 on 16: 3:2
      default:  return 0;
    endcase
  endfunction

  task automatic buildExp(input int bus, input int pix, input int n);
    int d = dOf(pix);
    int w = wOf(bus);
    int f = expFmt(bus, pix) & 3;
    logic [47:0] wm = (48'd1 << w) - 48'd1;
    logic [47:0] dm = (48'd1 << d) - 48'd1;
    expN = 0;
    if (f == 3) begin
      for (int i = 0; i < n; i += 2) begin
        logic [47:0] a = {24'd0, pixMem[i]} & dm;
        logic [47:0] b = (i + 1 < n) ? ({24'd0, pixMem[i+1]} & dm) : 48'd0;
        logic [47:0] cat = (a << d) | b;
        for (int k = 0; k < 3; k++) begin
          expW[expN] = 16'((cat >> (3 * w - (k + 1) * w)) & wm);
          expN++;
        end
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        logic [47:0] p = {24'd0, pixMem[i]} & dm;
        for (int k = 0; k <= f; k++) begin
          expW[expN] = 16'((p >> (d - (k + 1) * w)) & wm);
          expN++;
        end
      end
    end
  endtask

  task automatic produce(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixValid = 1'b1;
      pixData = pixMem[i];
      forever begin
        #1;
        if (pixReady) begin
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  task automatic consume(input bit stall, input string tag);
    for (int j = 0; j < expN; j++) begin
      forever begin
        @(negedge clk);
        wordReady = stall ? (cyc % 3 != 0) : 1'b1;
        cyc++;
        #1;
        if (wordValid && wordReady) begin
          chk(wordData == expW[j], tag, "word", int'(wordData), int'(expW[j]));
          @(posedge clk);
          break;
        end
      end
    end
    @(negedge clk);
    #1;
    // R8: pulse in the cycle after the last handshake, busy already low
    chk(frameDone == 1'b1, "R8", "frameDone high", int'(frameDone), 1);
    chk(busy == 1'b0, "R8", "busy cleared", int'(busy), 0);
    @(negedge clk);
    #1;
    chk(frameDone == 1'b0, "R8", "frameDone one clock", int'(frameDone), 0);
    wordReady = 1'b0;
  endtask

  task automatic runFrame(input int bus, input int pix, input int n, input bit stall,
                          input bit meddle, input string tag);
    buildExp(bus, pix, n);
    @(negedge clk);
    cfgBus = 2'(bus);
    cfgPix = 2'(pix);
    frameLen = 16'(n);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    #1;
    chk(busy == 1'b1, "R6", "busy after start", int'(busy), 1);
    if (meddle) begin
      // R7: new codes, length and start while busy must not disturb the frame
      @(negedge clk);
      cfgBus = 2'd3;
      cfgPix = 2'd3;
      frameLen = 16'd5;
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    fork
      produce(n);
      consume(stall, tag);
    join
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk(busy == 1'b0, "R10", "busy", int'(busy), 0);
    chk(frameDone == 1'b0, "R10", "frameDone", int'(frameDone), 0);
    chk(pixReady == 1'b0, "R10", "pixReady", int'(pixReady), 0);
    chk(wordValid == 1'b0, "R10", "wordValid", int'(wordValid), 0);
    chk(wordData == 16'd0, "R10", "wordData", int'(wordData), 0);
    rstN = 1'b1;

    // R1: format decode for every code pair
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        cfgBus = 2'(b);
        cfgPix = 2'(p);
        #1;
        chk({fmtOk, fmtCode} == 3'(expFmt(b, p)), "R1", "format decode",
            int'({fmtOk, fmtCode}), expFmt(b, p));
      end
    end

    // Vector table: R2 for n:1, R3 even 3:2, R4 odd 3:2; upper pixel bits are garbage (R5)
    for (int v = 0; v < 11; v++) begin
      int bus = int'(VEC[v][7:6]);
      int pix = int'(VEC[v][5:4]);
      int n = int'(VEC[v][3:0]);
      string tag;
      for (int i = 0; i < 8; i++)
        pixMem[i] = 24'hA5C3E1 ^ (24'(v) * 24'h13579B) ^ (24'(i) * 24'h2468AD);
      if ((expFmt(bus, pix) & 3) != 3) tag = "R2";
      else if (n % 2 == 1) tag = "R4";
      else tag = "R3";
      runFrame(bus, pix, n, v % 2 == 1, 1'b0, tag);
    end

    // R5: high garbage on a 16-bit pixel over 16 lines
    pixMem[0] = 24'hFF1234;
    pixMem[1] = 24'h80ABCD;
    runFrame(3, 1, 2, 1'b0, 1'b0, "R5");
    chk(expW[0] == 16'h1234, "R5", "model word", int'(expW[0]), 32'h1234);

    // R7: reconfiguration and restart while busy
    pixMem[0] = 24'h00BEEF;
    pixMem[1] = 24'h00CAFE;
    runFrame(0, 1, 2, 1'b0, 1'b1, "R7");
    @(negedge clk);
    #1;
    chk(busy == 1'b0, "R7", "stray start ignored", int'(busy), 0);

    // R6: unsupported pair is ignored
    @(negedge clk);
    cfgBus = 2'd1;
    cfgPix = 2'd0;
    frameLen = 16'd4;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    #1;
    chk(busy == 1'b0, "R6", "unsupported start", int'(busy), 0);
    chk(pixReady == 1'b0, "R6", "no pixel taken", int'(pixReady), 0);

    // R6: zero length is ignored
    @(negedge clk);
    cfgBus = 2'd3;
    cfgPix = 2'd1;
    frameLen = 16'd0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    #1;
    chk(busy == 1'b0, "R6", "zero length start", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule